// File: doc/BRIEF.md
# Decimal Adjust Unit

This is a combinational correction stage for a 16-bit accumulator. The accumulator is split into a high byte and a low byte. The stage takes the accumulator value, an incoming half-carry flag and a 2-bit operation select. It returns the corrected accumulator along with carry, half-carry and zero flags. It supports four operations:

- fix-up after an unpacked decimal add;
- fix-up after an unpacked decimal subtract;
- split after a multiply, which turns the low byte into two decimal digits;
- merge before a divide, which folds two digits into one binary byte.

The unit sits beside the main arithmetic path and is selected only when one of these four corrections runs. The split-after-multiply operation divides by ten. That step is built inside the unit as a restoring subtract-and-compare chain with a fixed divisor, so no general divider is needed.

Top module: `dadj_unit`

## Requirements
- R1: `op_i` selects the operation: 00 is add fix-up, 01 is subtract fix-up, 10 is multiply split, 11 is divide merge. For add and subtract fix-up, the correction is taken when bits [3:0] of the low byte exceed 9 or `af_i` is 1.
- R2: When the add correction is taken, the result is formed as follows, and `cf_o` and `af_o` are both 1:
  - the low byte becomes ((low + 6) AND 0x0F);
  - the high byte becomes (high + 1) modulo 256.
- R3: When the add or subtract correction is not taken:
  - the high byte passes through unchanged;
  - the low byte keeps only its bits [3:0], with the upper nibble cleared;
  - `cf_o` and `af_o` are 0.
- R4: When the subtract correction is taken, the result is formed as follows, and `cf_o` and `af_o` are both 1:
  - the low byte becomes ((low - 6) AND 0x0F);
  - the high byte becomes (high - 1) modulo 256.
- R5: Multiply split sets the high byte to low/10 and the low byte to low mod 10. This is exact for every low value from 0 to 255. `cf_o` and `af_o` are 0.
- R6: Divide merge sets the low byte to (high*10 + low) modulo 256 and the high byte to 0. `cf_o` and `af_o` are 0.
- R7: For add and subtract fix-up, `zf_o` is 1 exactly when both result bytes are zero.
- R8: For multiply split and divide merge, `zf_o` is 1 exactly when the result low byte is zero, whatever the high byte holds.
- R9: `af_i` has no effect on any output during multiply split or divide merge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 16 | Accumulator value; [15:8] is the high byte, [7:0] the low byte |
| af_i | input | 1 | Incoming half-carry flag |
| op_i | input | 2 | Operation select (see R1) |
| acc_o | output | 16 | Corrected accumulator |
| cf_o | output | 1 | Carry flag out |
| af_o | output | 1 | Half-carry flag out |
| zf_o | output | 1 | Zero flag out |

## Verification
The nibble correction and the wrap of the high byte can happen in the same evaluation. When that happens, the zero flag must see both bytes at once. The bench provokes this with two inputs:
- an add fix-up on 0xFF0A, which wraps the high byte to zero and leaves a low byte of zero;
- a subtract fix-up on 0x0003, which borrows through the high byte to 0xFF.

Both results are judged against the full 16-bit expected value and all three flags together. The multiply split is also swept over all 256 low-byte values, and the divide merge over all 256 low-byte values against a rotating high byte. Each sweep is compared with quotient, remainder and product values that the bench computes with plain integer arithmetic.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

  typedef enum logic [1:0] {
    DADJ_ADD = 2'b00,
    DADJ_SUB = 2'b01,
    DADJ_MUL = 2'b10,
    DADJ_DIV = 2'b11
  } dadj_op_e;

  localparam int NIB_W = 4;

  // Correction predicate shared by the add and subtract fix-ups.
  function automatic logic nib_over_nine(input logic [NIB_W-1:0] nib, input logic af);
    return (nib > NIB_W'(9)) || af;
  endfunction

  // Multiply by ten using shifts, truncated to the operand width.
  function automatic logic [7:0] times_ten8(input logic [7:0] v);
    return (v << 3) + (v << 1);
  endfunction

endpackage

// File: rtl/dadj_nibble_fix.sv
module dadj_nibble_fix
  import dadj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              taken_o
);
  localparam logic [BYTE_W-1:0] SIX = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  logic [BYTE_W-1:0] lo_adj;
  logic [BYTE_W-1:0] hi_adj;

  always_comb begin
    taken_o = nib_over_nine(lo_i[NIB_W-1:0], af_i);
    lo_adj  = sub_i ? (lo_i - SIX) : (lo_i + SIX);
    hi_adj  = sub_i ? (hi_i - ONE) : (hi_i + ONE);
    lo_o    = '0;
    lo_o[NIB_W-1:0] = taken_o ? lo_adj[NIB_W-1:0] : lo_i[NIB_W-1:0];
    hi_o    = taken_o ? hi_adj : hi_i;
  end

  // R3: an untaken correction leaves the high byte alone
  always_comb begin
    if (!taken_o) begin
      a_r3_hi_hold : assert (hi_o == hi_i)
        else $error("high byte moved without correction");
    end
  end

endmodule

// File: rtl/dadj_div10.sv
module dadj_div10 #(
  parameter int W = 8
) (
  input  logic [W-1:0]   dividend_i,
  output logic [W-4:0]   quot_o,
  output logic [3:0]     rem_o
);
  localparam int QW = W - 3;   // 2**W / 10 < 2**(W-3)
  localparam int XW = W + 4;

  logic [W-1:0] part [0:QW];

  assign part[0] = dividend_i;

  genvar g;
  generate
    for (g = 0; g < QW; g++) begin : g_stage
      localparam int SH = QW - 1 - g;
      localparam logic [W:0] DIV_SH = (W+1)'(10) << SH;
      logic ge;
      assign ge = {1'b0, part[g]} >= DIV_SH;
      assign part[g+1] = ge ? (part[g] - DIV_SH[W-1:0]) : part[g];
      assign quot_o[SH] = ge;
    end
  endgenerate

  assign rem_o = part[QW][3:0];

  // R5: remainder below ten and quotient*10+remainder rebuilds the dividend
  always_comb begin
    a_r5_rem_range : assert (part[QW] < W'(10))
      else $error("remainder out of range");
    a_r5_rebuild : assert ((XW'(quot_o) * XW'(10) + XW'(rem_o)) == XW'(dividend_i))
      else $error("quotient and remainder do not rebuild dividend");
  end

endmodule

// File: rtl/dadj_flags.sv
module dadj_flags
  import dadj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  dadj_op_e          op_i,
  input  logic              taken_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic              cf_o,
  output logic              af_o,
  output logic              zf_o
);
  logic lo_zero;
  logic hi_zero;
  logic is_fix;

  always_comb begin
    is_fix  = (op_i == DADJ_ADD) || (op_i == DADJ_SUB);
    lo_zero = (lo_i == '0);
    hi_zero = (hi_i == '0);
    cf_o    = is_fix && taken_i;
    af_o    = is_fix && taken_i;
    zf_o    = is_fix ? (lo_zero && hi_zero) : lo_zero;
  end

endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] acc_i,
  input  logic                af_i,
  input  logic [1:0]          op_i,
  output logic [2*BYTE_W-1:0] acc_o,
  output logic                cf_o,
  output logic                af_o,
  output logic                zf_o
);
  localparam int ACC_W = 2 * BYTE_W;
  localparam int QW    = BYTE_W - 3;

  dadj_op_e op;
  assign op = dadj_op_e'(op_i);

  logic [BYTE_W-1:0] hi_in, lo_in;
  assign hi_in = acc_i[ACC_W-1:BYTE_W];
  assign lo_in = acc_i[BYTE_W-1:0];

  // add / subtract fix-up path
  logic [BYTE_W-1:0] fix_hi, fix_lo;
  logic              fix_taken;
  logic              is_sub;
  assign is_sub = (op == DADJ_SUB);

  dadj_nibble_fix #(.BYTE_W(BYTE_W)) u_fix (
    .hi_i    (hi_in),
    .lo_i    (lo_in),
    .af_i    (af_i),
    .sub_i   (is_sub),
    .hi_o    (fix_hi),
    .lo_o    (fix_lo),
    .taken_o (fix_taken)
  );

  // multiply split path
  logic [QW-1:0] tens;
  logic [3:0]    units;

  dadj_div10 #(.W(BYTE_W)) u_div10 (
    .dividend_i (lo_in),
    .quot_o     (tens),
    .rem_o      (units)
  );

  // divide merge path
  logic [BYTE_W-1:0] merged;
  assign merged = times_ten8(hi_in) + lo_in;

  logic [BYTE_W-1:0] res_hi, res_lo;
  always_comb begin
    unique case (op)
      DADJ_ADD, DADJ_SUB: begin
        res_hi = fix_hi;
        res_lo = fix_lo;
      end
      DADJ_MUL: begin
        res_hi = BYTE_W'(tens);
        res_lo = BYTE_W'(units);
      end
      default: begin
        res_hi = '0;
        res_lo = merged;
      end
    endcase
  end

  assign acc_o = {res_hi, res_lo};

  dadj_flags #(.BYTE_W(BYTE_W)) u_flags (
    .op_i    (op),
    .taken_i (fix_taken),
    .hi_i    (res_hi),
    .lo_i    (res_lo),
    .cf_o    (cf_o),
    .af_o    (af_o),
    .zf_o    (zf_o)
  );

  // Assertions relating the assembled outputs to the inputs
  always_comb begin
    // R2 / R4: taken correction steps the high byte by exactly one
    if (!op_i[1] && fix_taken) begin
      a_r2_r4_hi_step : assert ((acc_o[ACC_W-1:BYTE_W] - hi_in) == (is_sub ? {BYTE_W{1'b1}} : BYTE_W'(1)))
        else $error("high byte not stepped by one");
      a_r2_r4_flags_set : assert (cf_o && af_o)
        else $error("flags not set on correction");
    end
    // R5 / R6: non-fix operations clear both carry flags
    if (op_i[1]) begin
      a_r6_carries_clear : assert (!cf_o && !af_o)
        else $error("carry flags set on split or merge");
    end
    if (op == DADJ_DIV) begin
      a_r6_hi_zero : assert (acc_o[ACC_W-1:BYTE_W] == '0)
        else $error("merge left high byte non-zero");
    end
    // R7: zero flag matches the whole result for add/subtract
    if (!op_i[1]) begin
      a_r7_zero_full : assert (zf_o == (acc_o == '0))
        else $error("zero flag mismatch on fix-up");
    end else begin
      // R8: zero flag follows only the low byte
      a_r8_zero_low : assert (zf_o == (acc_o[BYTE_W-1:0] == '0))
        else $error("zero flag mismatch on split/merge");
    end
  end

endmodule

// File: tb/dadj_unit_tb.sv
module dadj_unit_tb;

  logic        clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [15:0] acc_i;
  logic        af_i;
  logic [1:0]  op_i;
  logic [15:0] acc_o;
  logic        cf_o, af_o, zf_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  dadj_unit u_dut (
    .acc_i (acc_i),
    .af_i  (af_i),
    .op_i  (op_i),
    .acc_o (acc_o),
    .cf_o  (cf_o),
    .af_o  (af_o),
    .zf_o  (zf_o)
  );

  // {op, af_in, acc_in, acc_exp, cf, af, zf}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {2'b00, 1'b0, 16'h0105, 16'h0105, 1'b0, 1'b0, 1'b0},  // R3 no correction
    {2'b00, 1'b0, 16'h003B, 16'h0101, 1'b1, 1'b1, 1'b0},  // R2 nibble > 9
    {2'b00, 1'b1, 16'h0232, 16'h0308, 1'b1, 1'b1, 1'b0},  // R1 half-carry forces
    {2'b00, 1'b0, 16'h00F0, 16'h0000, 1'b0, 1'b0, 1'b1},  // R3 upper nibble cleared, R7
    {2'b00, 1'b0, 16'hFF0A, 16'h0000, 1'b1, 1'b1, 1'b1},  // R2 wrap with R7
    {2'b00, 1'b0, 16'h0009, 16'h0009, 1'b0, 1'b0, 1'b0},  // R1 boundary nine
    {2'b01, 1'b0, 16'h020C, 16'h0106, 1'b1, 1'b1, 1'b0},  // R4
    {2'b01, 1'b1, 16'h0003, 16'hFF0D, 1'b1, 1'b1, 1'b0},  // R4 borrow wrap
    {2'b01, 1'b0, 16'h0457, 16'h0407, 1'b0, 1'b0, 1'b0},  // R3 subtract untaken
    {2'b01, 1'b1, 16'h0106, 16'h0000, 1'b1, 1'b1, 1'b1},  // R4 with R7
    {2'b10, 1'b1, 16'h12FF, 16'h1905, 1'b0, 1'b0, 1'b0},  // R5 max, R9
    {2'b10, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1},  // R5 zero, R8
    {2'b10, 1'b0, 16'h3428, 16'h0400, 1'b0, 1'b0, 1'b1},  // R8 low zero only
    {2'b11, 1'b0, 16'h0307, 16'h0025, 1'b0, 1'b0, 1'b0},  // R6
    {2'b11, 1'b1, 16'h1906, 16'h0000, 1'b0, 1'b0, 1'b1},  // R6 truncation, R8, R9
    {2'b11, 1'b0, 16'hFFFF, 16'h00F5, 1'b0, 1'b0, 1'b0}   // R6 large
  };

  function automatic string tag_for(input logic [1:0] op);
    case (op)
      2'b00:   return "R1/R2/R3/R7 add";
      2'b01:   return "R1/R3/R4/R7 sub";
      2'b10:   return "R5/R8/R9 mul";
      default: return "R6/R8/R9 div";
    endcase
  endfunction

  task automatic apply(input logic [1:0] op, input logic af, input logic [15:0] acc);
    @(posedge clk);
    op_i  = op;
    af_i  = af;
    acc_i = acc;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual acc=%h cf=%b af=%b zf=%b expected acc=%h cf=%b af=%b zf=%b",
               req, act[18:3], act[2], act[1], act[0], exp[18:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_i = 2'b00; af_i = 1'b0; acc_i = 16'h0000;

    // Idle inputs: add fix-up on zero, nothing taken (R3, R7)
    apply(2'b00, 1'b0, 16'h0000);
    check("R3 idle", {acc_o, cf_o, af_o, zf_o}, {16'h0000, 3'b001});

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][37:36], VEC[i][35], VEC[i][34:19]);
      check(tag_for(VEC[i][37:36]), {acc_o, cf_o, af_o, zf_o}, VEC[i][18:0]);
    end

    // R5 sweep of every low byte, half-carry toggled for R9
    for (int v = 0; v < 256; v++) begin
      logic [15:0] e;
      e = {8'(v / 10), 8'(v % 10)};
      apply(2'b10, v[0], {8'(255 - v), 8'(v)});
      check("R5 sweep", {acc_o, cf_o, af_o, zf_o}, {e, 2'b00, (e[7:0] == 8'h00)});
    end

    // R6 sweep with rotating high byte
    for (int v = 0; v < 256; v++) begin
      int hi;
      logic [7:0] m;
      hi = (v * 37) % 256;
      m  = 8'((hi * 10 + v) % 256);
      apply(2'b11, v[1], {8'(hi), 8'(v)});
      check("R6 sweep", {acc_o, cf_o, af_o, zf_o}, {8'h00, m, 2'b00, (m == 8'h00)});
    end

    // R9: same input with both half-carry values must match
    apply(2'b10, 1'b0, 16'h00C3);
    check("R9 mul af=0", {acc_o, cf_o, af_o, zf_o}, {16'h1305, 3'b000});
    apply(2'b10, 1'b1, 16'h00C3);
    check("R9 mul af=1", {acc_o, cf_o, af_o, zf_o}, {16'h1305, 3'b000});

    // R3: nibble at zero with add select keeps high byte, no flags
    apply(2'b00, 1'b0, 16'h80A0);
    check("R3 hi hold", {acc_o, cf_o, af_o, zf_o}, {16'h8000, 3'b000});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule